// File: doc/BRIEF.md
# Banked Edge Interrupt Controller

This block gathers up to 55 external interrupt inputs into one host interrupt line. Each input passes through a two-stage synchronizer. It is then compared against a per-input polarity bit, so that either its rising or its falling transition is treated as an event. An event latches a sticky pending bit. Pending bits that are also enabled are ORed into the output line. That line is registered, so the host sees a clean rising edge whenever the first enabled interrupt becomes pending.

Software reaches the block through a small synchronous register port. Writes take effect on the clock edge. Reads are combinational from the presented address. The inputs are spread over two 32-bit banks, and each bank has three registers: enable, pending status and polarity. Pending status is read back from the same address that clears it: a bit written as 1 clears that bit. Bank 1 carries inputs 32 to 54 in its bits 0 to 22, and its upper bits are tied to zero.

Top module: `edge_irq_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, every enable, pending and polarity bit is zero and `irqOut` is low.
- R2: With polarity bit 0, a low-to-high transition of an input sets its pending bit. An input that merely stays high sets nothing new after its pending bit is cleared.
- R3: With polarity bit 1, a high-to-low transition of an input sets its pending bit, and a low-to-high transition does not.
- R4: A pending bit is set by an event whether or not its enable bit is set. A disabled pending bit does not raise `irqOut`.
- R5: Writing the status word of a bank clears each pending bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R6: If an event and a clearing write hit the same pending bit in the same clock cycle, the bit stays set.
- R7: On each rising clock edge, `irqOut` takes the OR over all inputs of (pending AND enabled) as it stood in the preceding cycle.
- R8: After every pending-and-enabled bit is cleared, `irqOut` goes low. A later enabled event drives it high again, which gives a fresh rising edge.
- R9: Input 32+k maps to bit k of every bank 1 register, for k from 0 to 22. Bits 23 to 31 of bank 1 always read 0 and ignore writes.
- R10: The byte offsets are 0x00 enable bank 0, 0x04 enable bank 1, 0x08 status bank 0, 0x0C status bank 1, 0x10 polarity bank 0 and 0x14 polarity bank 1. Any other offset, including one with nonzero bits [1:0], reads 0 and writes nothing.
- R11: An input transition presented between two clock edges shows up in the status read after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` |
| srcIn | input | 55 | Asynchronous interrupt inputs |
| irqOut | output | 1 | Host interrupt line |

## Verification
Two functions can meet in the same cycle: an incoming event setting a pending bit, and a software write clearing that same bit. The bench drops an input and then raises it again. It launches the status clear so that the write lands on exactly the edge at which the synchronized event is latched. It then expects the bit to read back as still pending. A second clear, one cycle later, must remove the bit. On every cycle the host line is also compared with a behavioural model, which shows that the collision never produces a glitch or a missed edge.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  parameter int EIRQ_BANKS = 2;

  typedef enum logic [1:0] {
    KIND_EN   = 2'd0,
    KIND_STAT = 2'd1,
    KIND_POL  = 2'd2,
    KIND_NONE = 2'd3
  } regKind_e;

  typedef struct packed {
    logic [EIRQ_BANKS-1:0] enWr;
    logic [EIRQ_BANKS-1:0] clrWr;
    logic [EIRQ_BANKS-1:0] polWr;
    logic [EIRQ_BANKS-1:0] rdBankSel;
    regKind_e              rdKind;
  } ctlStrobe_t;

endpackage

// File: rtl/edge_irq_decode.sv
module edge_irq_decode
  import edge_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobe_t        strb
);

  localparam int WIDX = ADDR_W - 2;

  logic [WIDX-1:0] wordIdx;
  logic [WIDX-1:0] kindIdx;
  logic [WIDX-1:0] bankIdx;
  regKind_e        kind;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign kindIdx = wordIdx / WIDX'(EIRQ_BANKS);
  assign bankIdx = wordIdx % WIDX'(EIRQ_BANKS);

  always_comb begin
    kind = KIND_NONE;
    if (regAddr[1:0] == 2'b00) begin
      if (kindIdx == WIDX'(0))      kind = KIND_EN;
      else if (kindIdx == WIDX'(1)) kind = KIND_STAT;
      else if (kindIdx == WIDX'(2)) kind = KIND_POL;
    end
  end

  always_comb begin
    strb = '0;
    strb.rdKind = kind;
    for (int b = 0; b < EIRQ_BANKS; b++) begin
      if (bankIdx == WIDX'(b)) begin
        strb.rdBankSel[b] = 1'b1;
        if (regWe) begin
          strb.enWr[b]  = (kind == KIND_EN);
          strb.clrWr[b] = (kind == KIND_STAT);
          strb.polWr[b] = (kind == KIND_POL);
        end
      end
    end
  end

endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int NUM_SRC = 55,
  parameter int BANK_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  ctlStrobe_t         strb,
  input  logic [BANK_W-1:0]  wdata,
  output logic [BANK_W-1:0]  rdata,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] enVec,
  output logic [NUM_SRC-1:0] edgeVec
);

  localparam int FULL_W = EIRQ_BANKS * BANK_W;

  logic [FULL_W-1:0] validMask;
  logic [FULL_W-1:0] srcFull;
  logic [FULL_W-1:0] syncA, syncB, prevNorm, normLvl, edgeFull;
  logic [FULL_W-1:0] enFull, polFull, pendFull;
  logic [FULL_W-1:0] enNext, polNext, clrFull;

  always_comb begin
    validMask = '0;
    validMask[NUM_SRC-1:0] = '1;
    srcFull = '0;
    srcFull[NUM_SRC-1:0] = srcIn;
  end

  // Polarity folds falling-edge inputs onto a rising-edge detector.
  assign normLvl  = syncB ^ polFull;
  assign edgeFull = normLvl & ~prevNorm & validMask;

  always_comb begin
    enNext  = enFull;
    polNext = polFull;
    clrFull = '0;
    for (int b = 0; b < EIRQ_BANKS; b++) begin
      if (strb.enWr[b])  enNext[b*BANK_W +: BANK_W]  = wdata;
      if (strb.polWr[b]) polNext[b*BANK_W +: BANK_W] = wdata;
      if (strb.clrWr[b]) clrFull[b*BANK_W +: BANK_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      prevNorm <= '0;
      enFull   <= '0;
      polFull  <= '0;
      pendFull <= '0;
      irqOut   <= 1'b0;
    end else begin
      syncA    <= srcFull;
      syncB    <= syncA;
      prevNorm <= normLvl;
      enFull   <= enNext & validMask;
      polFull  <= polNext & validMask;
      // Event beats clear on the same bit.
      pendFull <= ((pendFull & ~clrFull) | edgeFull) & validMask;
      irqOut   <= |(pendFull & enFull);
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < EIRQ_BANKS; b++) begin
      if (strb.rdBankSel[b]) begin
        case (strb.rdKind)
          KIND_EN:   rdata = enFull[b*BANK_W +: BANK_W];
          KIND_STAT: rdata = pendFull[b*BANK_W +: BANK_W];
          KIND_POL:  rdata = polFull[b*BANK_W +: BANK_W];
          default:   rdata = '0;
        endcase
      end
    end
  end

  assign pendVec = pendFull[NUM_SRC-1:0];
  assign enVec   = enFull[NUM_SRC-1:0];
  assign edgeVec = edgeFull[NUM_SRC-1:0];

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_SRC = 55,
  parameter int BANK_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [BANK_W-1:0]  regWdata,
  output logic [BANK_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);

  ctlStrobe_t         strb;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] enVec;
  logic [NUM_SRC-1:0] edgeVec;

  edge_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  edge_irq_datapath #(.NUM_SRC(NUM_SRC), .BANK_W(BANK_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .strb    (strb),
    .wdata   (regWdata),
    .rdata   (regRdata),
    .irqOut  (irqOut),
    .pendVec (pendVec),
    .enVec   (enVec),
    .edgeVec (edgeVec)
  );

endmodule

// File: rtl/edge_irq_checker.sv
module edge_irq_checker #(
  parameter int NUM_SRC = 55,
  parameter int BANK_W  = 32,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [BANK_W-1:0]  regWdata,
  input logic [BANK_W-1:0]  regRdata,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] enVec,
  input logic [NUM_SRC-1:0] edgeVec
);

  localparam logic [ADDR_W-1:0] CLR0_ADDR = ADDR_W'(8);
  localparam int HI_USED = NUM_SRC - BANK_W;

  logic bank1Read;
  assign bank1Read = (regAddr == ADDR_W'(4)) || (regAddr == ADDR_W'(12)) ||
                     (regAddr == ADDR_W'(20));

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (pendVec == '0 && enVec == '0 && !irqOut));

  // R7
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|(pendVec & enVec)));

  // R2
  p_set_needs_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & ~$past(pendVec) & ~$past(edgeVec)) == '0);

  // R6
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & $past(edgeVec)) == $past(edgeVec));

  // R5
  p_clear_bank0_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == CLR0_ADDR) |=>
      (pendVec[BANK_W-1:0] & $past(regWdata & ~edgeVec[BANK_W-1:0])) == '0);

  // R9
  p_hi_bits_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    bank1Read |-> regRdata[BANK_W-1:HI_USED] == '0);

endmodule

bind edge_irq_ctrl edge_irq_checker #(
  .NUM_SRC(NUM_SRC), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .irqOut   (irqOut),
  .pendVec  (pendVec),
  .enVec    (enVec),
  .edgeVec  (edgeVec)
);

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;

  localparam int NS = 55;
  localparam int BW = 32;
  localparam int AW = 5;
  localparam logic [4:0] EN0 = 5'h00, EN1 = 5'h04, ST0 = 5'h08,
                         ST1 = 5'h0C, PL0 = 5'h10, PL1 = 5'h14;
  localparam logic [63:0] VALID = (64'd1 << NS) - 64'd1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [BW-1:0] regWdata = '0;
  logic [BW-1:0] regRdata;
  logic [NS-1:0] srcIn = '0;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  edge_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .srcIn(srcIn), .irqOut(irqOut)
  );

  // Behavioural reference for the host line.
  logic [63:0] mS1, mS2, mPrev, mPend, mEn, mPol;
  logic        mIrq;

  always @(posedge clk or negedge rstN) begin
    logic [63:0] norm, evt, clr, wd;
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mPend = '0; mEn = '0; mPol = '0;
      mIrq = 1'b0;
    end else begin
      norm = mS2 ^ mPol;
      evt  = norm & ~mPrev & VALID;
      mIrq = |(mPend & mEn);
      clr  = '0;
      wd   = {32'd0, regWdata};
      if (regWe && regAddr[1:0] == 2'b00) begin
        case (regAddr[4:2])
          3'd0: mEn = {mEn[63:32], regWdata};
          3'd1: mEn = {regWdata, mEn[31:0]} & VALID;
          3'd2: clr = wd;
          3'd3: clr = wd << 32;
          3'd4: mPol = {mPol[63:32], regWdata};
          3'd5: mPol = {regWdata, mPol[31:0]} & VALID;
          default: ;
        endcase
      end
      mPend = ((mPend & ~clr) | evt) & VALID;
      mPrev = norm;
      mS2   = mS1;
      mS1   = {9'd0, srcIn};
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) chk(irqOut == mIrq, "R7 model irqOut", irqOut, mIrq);
  end

  task automatic readReg(input logic [4:0] a, input logic [31:0] exp,
                         input string tag);
    regAddr = a;
    #1;
    chk(regRdata == exp, tag, regRdata, exp);
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    waitCyc(3);
    // R1: reset state
    chk(irqOut == 1'b0, "R1 irqOut in reset", irqOut, 0);
    rstN = 1'b1;
    waitCyc(1);
    readReg(EN0, 0, "R1 en0"); readReg(EN1, 0, "R1 en1");
    readReg(ST0, 0, "R1 st0"); readReg(ST1, 0, "R1 st1");
    readReg(PL0, 0, "R1 pl0"); readReg(PL1, 0, "R1 pl1");
    chk(irqOut == 1'b0, "R1 irqOut after reset", irqOut, 0);

    // R10 / R9: map and unused bits
    writeReg(EN0, 32'hFFFF_FFFF); readReg(EN0, 32'hFFFF_FFFF, "R10 en0 rw");
    writeReg(EN1, 32'hFFFF_FFFF); readReg(EN1, 32'h007F_FFFF, "R9 en1 upper bits");
    readReg(5'h18, 0, "R10 unmapped offset");
    readReg(5'h01, 0, "R10 misaligned offset");
    writeReg(5'h02, 32'h0); readReg(EN0, 32'hFFFF_FFFF, "R10 misaligned write ignored");
    writeReg(EN0, 0); writeReg(EN1, 0);
    readReg(EN0, 0, "R10 en0 cleared");

    // R11 / R4: latency, disabled pending
    srcIn[5] = 1'b1;
    waitCyc(2); readReg(ST0, 0, "R11 not yet after two edges");
    waitCyc(1); readReg(ST0, 32'h20, "R11 pending after third edge");
    chk(irqOut == 1'b0, "R4 disabled no irq", irqOut, 0);

    // R7: enable raises line one cycle later
    writeReg(EN0, 32'h20);
    chk(irqOut == 1'b0, "R7 one cycle lag", irqOut, 0);
    waitCyc(1);
    chk(irqOut == 1'b1, "R7 irq high", irqOut, 1);

    // R2 / R8: clear while input holds high
    writeReg(ST0, 32'h20);
    waitCyc(4);
    readReg(ST0, 0, "R2 held level no re-pend");
    chk(irqOut == 1'b0, "R8 line low after clear", irqOut, 0);

    // R8: fresh edge
    srcIn[5] = 1'b0; waitCyc(3);
    srcIn[5] = 1'b1; waitCyc(4);
    chk(irqOut == 1'b1, "R8 fresh rising edge", irqOut, 1);
    writeReg(ST0, 32'hFFFF_FFFF); writeReg(ST1, 32'hFFFF_FFFF);
    readReg(ST0, 0, "R5 clear all bank0"); readReg(ST1, 0, "R5 clear all bank1");
    waitCyc(1);
    chk(irqOut == 1'b0, "R8 low after clear all", irqOut, 0);

    // R2 / R3: polarity
    srcIn[7] = 1'b1; waitCyc(3);
    readReg(ST0, 32'h80, "R2 rising edge pends");
    writeReg(ST0, 32'h80);
    writeReg(PL0, 32'h80); readReg(PL0, 32'h80, "R10 polarity rw");
    waitCyc(3); readReg(ST0, 0, "R3 no event at polarity change");
    srcIn[7] = 1'b0; waitCyc(3);
    readReg(ST0, 32'h80, "R3 falling edge pends");
    writeReg(ST0, 32'h80);
    srcIn[7] = 1'b1; waitCyc(4);
    readReg(ST0, 0, "R3 rising ignored with polarity 1");

    // R5: selective clear
    srcIn[10] = 1'b1; srcIn[12] = 1'b1; waitCyc(3);
    readReg(ST0, 32'h1400, "R5 two pending");
    writeReg(ST0, 0); readReg(ST0, 32'h1400, "R5 zero write no effect");
    writeReg(ST0, 32'h400); readReg(ST0, 32'h1000, "R5 one bit cleared");
    writeReg(ST0, 32'h1000);

    // R9: bank 1 mapping
    writeReg(EN1, 32'h100);
    srcIn[40] = 1'b1; srcIn[54] = 1'b1; waitCyc(3);
    readReg(ST1, 32'h0040_0100, "R9 sources 40 and 54 in bank1");
    readReg(ST0, 0, "R9 bank0 untouched");
    waitCyc(1);
    chk(irqOut == 1'b1, "R9 bank1 enabled irq", irqOut, 1);
    writeReg(ST1, 32'hFF80_0000); readReg(ST1, 32'h0040_0100, "R9 unused clear bits");
    writeReg(ST1, 32'h0040_0100); readReg(ST1, 0, "R9 bank1 cleared");

    // R6: event and clear in the same cycle
    srcIn[20] = 1'b1; waitCyc(3);
    readReg(ST0, 32'h10_0000, "R6 setup pending");
    srcIn[20] = 1'b0; waitCyc(3);
    srcIn[20] = 1'b1; waitCyc(2);
    writeReg(ST0, 32'h10_0000);
    readReg(ST0, 32'h10_0000, "R6 event wins over clear");
    writeReg(ST0, 32'h10_0000);
    readReg(ST0, 0, "R5 later clear removes bit");

    waitCyc(3);
    summary();
  end

endmodule